// File: doc/BRIEF.md
# Serial DAC Word Receiver

This block is the receiving end of a three-wire serial link that loads a 12-bit digital-to-analog converter. A frame opens when the active-low frame strobe `sync_n` falls. While it is low, one 16-bit word arrives on `sdin`, most significant bit first, and one bit is taken on each capturing edge of `sclk`. When `sync_n` returns high after a complete word, the low twelve bits are copied into the parallel DAC code register. An update strobe marks that copy.

After reset, bits are taken on the falling edge of `sclk`. The two top bits of each word form a control field. It can move capture to the rising edge, or back to the falling edge, for the frames that follow. The new setting takes effect at the same moment as the DAC code load.

All three link inputs are sampled by a faster system clock through a synchronizer, and their edges are found in that clock domain, so the block has a single clock. A frame cut short is dropped without any effect. Clock edges that arrive after the sixteenth bit are ignored.

Top module: `sdac_rx`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a `clk` edge), `dac_code` is 0, `dac_upd` is 0 and `cap_rise` is 0, so capture is on the falling edge of `sclk`.
- R2: The bits of a frame are taken MSB first (word bit 15 first, bit 0 last), one bit on each capturing `sclk` edge seen while `sync_n` is low. The capturing edge is falling when `cap_rise` is 0 and rising when it is 1.
- R3: The control field is word bits 15:14. The value 2'b11 sets `cap_rise` to 1 and 2'b10 sets it to 0, both effective from the next frame. The values 2'b00 and 2'b01 leave `cap_rise` unchanged.
- R4: `dac_code` takes word bits 11:0. Word bits 13:12 have no effect on any output.
- R5: `dac_code` never changes while a frame is open. It loads only after `sync_n` rises.
- R6: If `sync_n` rises after fewer than 16 capturing edges, the frame is dropped. `dac_code` and `cap_rise` keep their values and no `dac_upd` pulse is produced.
- R7: Capturing edges after the sixteenth bit of a frame are ignored. The word used is the first 16 bits received.
- R8: Each complete frame produces exactly one `dac_upd` pulse, one `clk` cycle wide, in the same cycle in which the new `dac_code` first appears. A few `clk` cycles of synchronizer latency after the rise of `sync_n` are expected.
- R9: `cap_rise` changes only in a cycle in which `dac_upd` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_n | input | 1 | Active-low frame strobe, asynchronous to `clk` |
| sclk | input | 1 | Serial bit clock, asynchronous to `clk` |
| sdin | input | 1 | Serial data, MSB first |
| dac_code | output | 12 | Parallel DAC code register |
| dac_upd | output | 1 | One-cycle pulse when `dac_code` loads |
| cap_rise | output | 1 | Capture edge setting: 1 rising, 0 falling |

## Verification
A bit counter in the wrong state shows up when `sync_n` rises:
- A count that stopped short drops a good frame, so `dac_upd` stays low and `dac_code` keeps its old value.
- A count that runs past sixteen lets late edges shift the word, so a shifted code appears a few `clk` cycles after the frame closes.

A wrong capture-edge flag shows up on the next full frame. The bench drives different bit values before the falling edge and before the rising edge of each `sclk` pulse, so the code that loads shows which edge was used. The `dac_code` value seen in the middle of a frame shows any register that loads too early.

// File: rtl/sdac_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and encodings for the serial DAC word receiver.
// Assumes one fixed word layout: control field on top, code field at the bottom.
package sdac_pkg;
    localparam int WORD_W = 16;
    localparam int CODE_W = 12;
    localparam int CTRL_W = 2;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    // Meaning of the control field at the top of the word
    typedef enum logic [CTRL_W-1:0] {
        CTL_HOLD_A = 2'b00,
        CTL_HOLD_B = 2'b01,
        CTL_FALL   = 2'b10,
        CTL_RISE   = 2'b11
    } ctl_e;
endpackage

// File: rtl/sdac_sync.sv
`timescale 1ns/1ps
// Module: sdac_sync
// Brings N asynchronous inputs into the clk domain through a STAGES-deep flop
// chain, then flags rising and falling transitions of the synchronized level.
// Assumes each input holds every level for at least STAGES+1 clk cycles.
module sdac_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES:0] chain_q;

        // Purpose: shift the raw input through the synchronizer plus one history flop
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= {(STAGES+1){RST_VAL[g]}};
            else        chain_q <= {chain_q[STAGES-1:0], din[g]};
        end

        assign lvl[g]  = chain_q[STAGES-1];
        assign rise[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
        assign fall[g] = ~chain_q[STAGES-1] & chain_q[STAGES];
    end
endmodule

// File: rtl/sdac_shift.sv
`timescale 1ns/1ps
// Module: sdac_shift
// Counts and shifts in the serial bits of one frame on the selected bit-clock
// edge. It reports a complete frame when the frame strobe rises after a full word.
// Assumes the edge pulses and levels come from sdac_sync, so all are in the clk domain.
module sdac_shift
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_lvl,     // synchronized sync_n level
    input  logic              frm_rise,
    input  logic              frm_fall,
    input  logic              bclk_rise,
    input  logic              bclk_fall,
    input  logic              bit_lvl,
    input  logic              edge_rise,   // 1: capture on rising edge
    output logic [WORD_W-1:0] word_o,
    output logic              done_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] sreg_q;
    logic              cap;
    logic              full;

    assign cap  = edge_rise ? bclk_rise : bclk_fall;
    assign full = (cnt_q == FULL);

    // Purpose: count captured bits; restart when a new frame opens
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (frm_fall)                cnt_q <= '0;
        else if (!frm_lvl && cap && !full) cnt_q <= cnt_q + 1'b1;
    end

    // Purpose: shift one bit in, MSB first, on each accepted capture edge
    always_ff @(posedge clk) begin
        if (!rst_n)                                   sreg_q <= '0;
        else if (!frm_fall && !frm_lvl && cap && !full) sreg_q <= {sreg_q[WORD_W-2:0], bit_lvl};
    end

    assign word_o = sreg_q;
    assign done_o = frm_rise && full;

    // R6: the bit count never exceeds one word
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

    // R7: once a word is complete inside an open frame, the shift register holds
    a_r7_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !frm_lvl) |=> $stable(sreg_q));

    // R6: a frame is never reported complete while the strobe is still low
    a_r6_done_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> frm_lvl);
endmodule

// File: rtl/sdac_out.sv
`timescale 1ns/1ps
// Module: sdac_out
// Holds the parallel DAC code and the capture edge setting. Both load from a
// completed word in one cycle, and a one-cycle update pulse marks the load.
// Assumes done_i is a single-cycle pulse and word_i is stable while it is high.
module sdac_out
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [CODE_W-1:0] code_o,
    output logic              upd_o,
    output logic              edge_rise_o
);
    ctl_e ctl;
    assign ctl = ctl_e'(word_i[WORD_W-1 -: CTRL_W]);

    // Purpose: load the code field and raise the update pulse on a completed frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= '0;
            upd_o  <= 1'b0;
        end else begin
            upd_o <= done_i;
            if (done_i) code_o <= word_i[CODE_W-1:0];
        end
    end

    // Purpose: apply the edge-select control field of a completed frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_rise_o <= 1'b0;
        end else if (done_i) begin
            case (ctl)
                CTL_RISE: edge_rise_o <= 1'b1;
                CTL_FALL: edge_rise_o <= 1'b0;
                default:  edge_rise_o <= edge_rise_o;
            endcase
        end
    end

    // R8: the update pulse lasts exactly one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);

    // R5: the code register changes only together with the update pulse
    a_r5_code_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o != $past(code_o)) |-> upd_o);

    // R9: the edge setting changes only together with the update pulse
    a_r9_edge_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_rise_o != $past(edge_rise_o)) |-> upd_o);
endmodule

// File: rtl/sdac_rx.sv
`timescale 1ns/1ps
// Module: sdac_rx (top)
// Slave receiver for a three-wire serial DAC link. It synchronizes the link into
// clk, shifts in one 16-bit word per frame and loads the DAC code and edge setting
// when the frame closes.
// Assumes clk is fast enough that every sclk and sync_n level lasts several clk cycles.
module sdac_rx
    import sdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n,
    input  logic              sclk,
    input  logic              sdin,
    output logic [CODE_W-1:0] dac_code,
    output logic              dac_upd,
    output logic              cap_rise
);
    localparam int NSIG = 3;   // [0] frame strobe, [1] bit clock, [2] data

    logic [NSIG-1:0]   s_lvl, s_rise, s_fall;
    logic [1:0]        data_edges_unused;
    logic [WORD_W-1:0] word;
    logic              done;

    assign data_edges_unused = {s_rise[2], s_fall[2]};

    sdac_sync #(
        .N      (NSIG),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b011)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sdin, sclk, sync_n}),
        .lvl  (s_lvl),
        .rise (s_rise),
        .fall (s_fall)
    );

    sdac_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_lvl  (s_lvl[0]),
        .frm_rise (s_rise[0]),
        .frm_fall (s_fall[0]),
        .bclk_rise(s_rise[1]),
        .bclk_fall(s_fall[1]),
        .bit_lvl  (s_lvl[2]),
        .edge_rise(cap_rise),
        .word_o   (word),
        .done_o   (done)
    );

    sdac_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (done),
        .word_i     (word),
        .code_o     (dac_code),
        .upd_o      (dac_upd),
        .edge_rise_o(cap_rise)
    );

    // R8: a completed frame is followed by an update pulse on the next cycle
    a_r8_done_gives_update: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> dac_upd);
endmodule

// File: tb/tb_sdac_rx.sv
`timescale 1ns/1ps
// Bench for sdac_rx: a vector table of frames walked by one loop, then directed
// reset and post-reset checks. Expected values come from a small behavioural model.
module tb_sdac_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdin = 1'b0;
    logic [11:0] dac_code;
    logic        dac_upd;
    logic        cap_rise;

    sdac_rx dut (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
        .dac_code(dac_code), .dac_upd(dac_upd), .cap_rise(cap_rise)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    int cyc    = 0;
    bit done   = 0;

    // model state
    logic [11:0] m_code = '0;
    logic        m_rise = 1'b0;
    int          m_pulses = 0;

    // vectors: word on falling-edge slots, word on rising-edge slots, bit count, extra pulses
    localparam int NV = 13;
    localparam logic [15:0] VF [NV] = '{16'h0ABC, 16'h3123, 16'hC7E5, 16'h0111, 16'h0FFF,
                                        16'hC000, 16'h0000, 16'h8FFF, 16'hC000, 16'h0246,
                                        16'h0000, 16'hC800, 16'hFFFF};
    localparam logic [15:0] VR [NV] = '{16'h0555, 16'h0000, 16'h0F0F, 16'h0A5A, 16'h4321,
                                        16'hC9A5, 16'h8001, 16'h0000, 16'hC000, 16'hFFFF,
                                        16'hFFFF, 16'h0000, 16'h3FFF};
    localparam int VN [NV] = '{16, 16, 16, 16, 16, 15, 16, 16, 9, 16, 16, 16, 16};
    localparam int VX [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 0, 0, 2};

    // Purpose: count update pulses, sampled away from the active edge
    always @(negedge clk) if (rst_n && dac_upd) pulses++;

    // Purpose: watchdog that turns a hung run into a failure
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [15:0] wf, input logic [15:0] wr,
                             input int nbits, input int extra);
        sync_n = 1'b0;
        wait_clk(4);                       // 20 ns setup before first edge
        for (int i = 0; i < nbits; i++) begin
            sdin = wf[15-i]; wait_clk(3);
            sclk = 1'b0;     wait_clk(3);
            sdin = wr[15-i]; wait_clk(3);
            sclk = 1'b1;     wait_clk(3);
        end
        for (int i = 0; i < extra; i++) begin
            sdin = ~sdin; wait_clk(3);
            sclk = 1'b0;  wait_clk(3);
            sdin = ~sdin; wait_clk(3);
            sclk = 1'b1;  wait_clk(3);
        end
        wait_clk(4);
    endtask

    task automatic close_frame();
        sync_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic model_frame(input logic [15:0] wf, input logic [15:0] wr, input int nbits);
        logic [15:0] w;
        if (nbits >= 16) begin
            w = m_rise ? wr : wf;
            m_code = w[11:0];
            m_pulses++;
            if (w[15:14] == 2'b11)      m_rise = 1'b1;
            else if (w[15:14] == 2'b10) m_rise = 1'b0;
        end
    endtask

    initial begin
        string req;
        wait_clk(5);
        // R1: reset state
        check("R1", "dac_code after reset", int'(dac_code), 0);
        check("R1", "dac_upd after reset", int'(dac_upd), 0);
        check("R1", "cap_rise after reset", int'(cap_rise), 0);
        rst_n = 1'b1;
        wait_clk(4);

        for (int v = 0; v < NV; v++) begin
            if (VN[v] < 16)     req = "R6";
            else if (VX[v] > 0) req = "R7";
            else                req = "R2/R3/R4";
            send_bits(VF[v], VR[v], VN[v], VX[v]);
            // R5: nothing loads while the frame is open
            check("R5", "code mid-frame", int'(dac_code), int'(m_code));
            check("R8", "no pulse mid-frame", pulses, m_pulses);
            close_frame();
            model_frame(VF[v], VR[v], VN[v]);
            check(req, $sformatf("vector %0d dac_code", v), int'(dac_code), int'(m_code));
            check(req == "R6" ? "R6" : "R9", $sformatf("vector %0d cap_rise", v),
                  int'(cap_rise), int'(m_rise));
            check(req == "R6" ? "R6" : "R8", $sformatf("vector %0d pulse count", v),
                  pulses, m_pulses);
        end

        // R3: switch to rising capture, then reset must restore falling capture (R1)
        send_bits(16'hC5A5, 16'hC5A5, 16, 0);
        close_frame();
        model_frame(16'hC5A5, 16'hC5A5, 16);
        check("R3", "rising selected before reset", int'(cap_rise), 1);
        rst_n = 1'b0;
        wait_clk(3);
        check("R1", "dac_code in reset", int'(dac_code), 0);
        check("R1", "cap_rise in reset", int'(cap_rise), 0);
        check("R1", "dac_upd in reset", int'(dac_upd), 0);
        rst_n = 1'b1;
        m_code = '0;
        m_rise = 1'b0;
        wait_clk(4);
        // R1/R2: the first frame after reset is captured on falling edges
        send_bits(16'h0123, 16'h0456, 16, 0);
        close_frame();
        model_frame(16'h0123, 16'h0456, 16);
        check("R2", "falling capture after reset", int'(dac_code), 12'h123);
        check("R8", "pulse after reset frame", pulses, m_pulses);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule